// File: doc/BRIEF.md
# Variable Page Size TLB Lookup

This block is a small, fully associative data translation buffer. Each slot has a tag half and a data half. The tag half holds an effective page number, a valid bit, a page size code, a shared flag and a 4-bit address space identifier. The data half holds a real page number, a page size code, a protection group stored inverted, and the guarded, write-through and cache-inhibit bits. Each slot's own page size decides how many low page number bits take part in the compare. A set shared flag makes the slot match in every address space.

A lookup presents an effective address and the current address space identifier. One clock later the block returns a hit flag, a multi-hit flag, the translated physical address and the attributes of the winning slot.

Software writes slots through a slot index register, a data write strobe and a tag write strobe. Every tag write also refreshes a pair of readback registers with the indexed slot, so software can inspect what it stored.

Top module: `vtlb_top`

## Requirements
- R1: After reset every slot is invalid, so every lookup misses. The readback registers and the slot index are zero, and lk_done, lk_hit and lk_multi are low.
- R2: A lookup sampled with lk_req high at a clock edge drives its result on the outputs after that edge. lk_done is high in exactly the cycle after a cycle with lk_req high, and low otherwise.
- R3: The page size code sets how many low bits of the effective page number (ea[31:12]) are left out of the compare. Code 000 (4 KB) leaves out none, 001 (16 KB) the low 2, 011 (512 KB) the low 7, and 111 (8 MB) the low 11. The tag-side code is the one used.
- R4: A slot never matches if its valid bit is 0 or if its tag page size code is reserved (010, 100, 101 or 110).
- R5: A slot whose shared bit is 0 matches only when its address space identifier equals lk_asid. A slot whose shared bit is 1 ignores lk_asid.
- R6: On a hit, lk_pa is built as follows. The compared upper bits of the page number come from the slot's real page number. The bits left out of the compare, and ea[11:0], come from the effective address.
- R7: When more than one slot matches, the lowest-index slot supplies the result and lk_multi is high. With exactly one match, lk_multi is low.
- R8: On a hit, lk_prot is the bitwise inverse of the stored protection field, and lk_guarded, lk_wt and lk_ci copy the slot's bits. On a miss, lk_pa, lk_prot and the three attribute bits are zero.
- R9: A slot write in cycle t is seen by a lookup requested in cycle t+1. A lookup requested in cycle t itself sees the old slot.
- R10: A tag write loads rb_tag with the written tag word. In the same edge it loads rb_data with the indexed slot's data half, including a data write made in that same cycle. Without a tag write, both readback registers hold their value, even across a data write.
- R11: Tag word layout: [28:9] page number, [8] valid, [7:5] page size, [4] shared, [3:0] address space identifier. Data word layout: [29:10] real page number, [9:7] page size, [6:3] inverted protection group, [2] guarded, [1] write-through, [0] cache-inhibit. Tag and data writes go to the slot given by the index register value before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_ea | input | 32 | Effective address to translate |
| lk_asid | input | 4 | Current address space identifier |
| sw_idx_we | input | 1 | Load slot index register |
| sw_idx_wdata | input | 5 | New slot index |
| sw_data_we | input | 1 | Write data half of indexed slot |
| sw_data_wdata | input | 30 | Data word |
| sw_tag_we | input | 1 | Write tag half of indexed slot and refresh readback |
| sw_tag_wdata | input | 29 | Tag word |
| lk_done | output | 1 | Lookup result valid |
| lk_hit | output | 1 | A slot matched |
| lk_multi | output | 1 | More than one slot matched |
| lk_pa | output | 32 | Physical address |
| lk_prot | output | 4 | Protection group, true form |
| lk_guarded | output | 1 | Guarded attribute |
| lk_wt | output | 1 | Write-through attribute |
| lk_ci | output | 1 | Cache-inhibit attribute |
| rb_tag | output | 29 | Readback of indexed tag half |
| rb_data | output | 30 | Readback of indexed data half |

## Verification
The lookup result is due one edge after the request. The bench raises lk_req on a falling edge and compares all outputs on the next falling edge. It then checks that lk_done drops again one edge after the request is withdrawn. Readback registers change on the edge of a tag write, so they are sampled on the falling edge that follows that write. The bench also checks that they are unchanged one edge after a data write alone. For the same-cycle case, the bench issues a tag write and a lookup on the same falling edge and expects the old contents. A lookup one cycle later must see the new entry.

// File: rtl/vtlb_pkg.sv
package vtlb_pkg;

    localparam int EA_W   = 32;
    localparam int OFS_W  = 12;
    localparam int PN_W   = EA_W - OFS_W;
    localparam int ASID_W = 4;
    localparam int PS_W   = 3;
    localparam int APG_W  = 4;

    localparam logic [PS_W-1:0] PG_4K   = 3'b000;
    localparam logic [PS_W-1:0] PG_16K  = 3'b001;
    localparam logic [PS_W-1:0] PG_512K = 3'b011;
    localparam logic [PS_W-1:0] PG_8M   = 3'b111;

    typedef struct packed {
        logic [PN_W-1:0]   epn;
        logic              valid;
        logic [PS_W-1:0]   ps;
        logic              shared;
        logic [ASID_W-1:0] asid;
    } tag_t;

    typedef struct packed {
        logic [PN_W-1:0]  rpn;
        logic [PS_W-1:0]  ps;
        logic [APG_W-1:0] apg_inv;
        logic             guarded;
        logic             wt;
        logic             ci;
    } data_t;

    localparam int TAG_W  = $bits(tag_t);
    localparam int DATA_W = $bits(data_t);

    typedef struct packed {
        logic             done;
        logic             hit;
        logic             multi;
        logic [EA_W-1:0]  pa;
        logic [APG_W-1:0] prot;
        logic             guarded;
        logic             wt;
        logic             ci;
    } res_t;

    function automatic logic ps_legal(input logic [PS_W-1:0] ps);
        case (ps)
            PG_4K, PG_16K, PG_512K, PG_8M: ps_legal = 1'b1;
            default:                       ps_legal = 1'b0;
        endcase
    endfunction

    // ones over the page-number bits that take part in the compare
    function automatic logic [PN_W-1:0] ps_mask(input logic [PS_W-1:0] ps);
        case (ps)
            PG_16K:  ps_mask = {PN_W{1'b1}} << 2;
            PG_512K: ps_mask = {PN_W{1'b1}} << 7;
            PG_8M:   ps_mask = {PN_W{1'b1}} << 11;
            default: ps_mask = {PN_W{1'b1}};
        endcase
    endfunction

    function automatic logic [EA_W-1:0] make_pa(input logic [EA_W-1:0] ea,
                                                 input logic [PN_W-1:0] rpn,
                                                 input logic [PS_W-1:0] ps);
        logic [PN_W-1:0] m;
        m = ps_mask(ps);
        make_pa = {(rpn & m) | (ea[EA_W-1:OFS_W] & ~m), ea[OFS_W-1:0]};
    endfunction

endpackage

// File: rtl/vtlb_match.sv
module vtlb_match
    import vtlb_pkg::*;
#(
    parameter int ENTRIES = 32
) (
    input  tag_t [ENTRIES-1:0] tags,
    input  logic [PN_W-1:0]    ea_pn,
    input  logic [ASID_W-1:0]  cur_asid,
    output logic [ENTRIES-1:0] hit_vec
);

    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        logic pn_eq_d;
        logic asid_ok_d;
        always_comb begin
            pn_eq_d   = ((tags[i].epn ^ ea_pn) & ps_mask(tags[i].ps)) == '0;
            asid_ok_d = tags[i].shared || (tags[i].asid == cur_asid);
            hit_vec[i] = tags[i].valid && ps_legal(tags[i].ps) && pn_eq_d && asid_ok_d;
        end
    end

endmodule

// File: rtl/vtlb_prio.sv
module vtlb_prio #(
    parameter int ENTRIES = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] hit_vec,
    output logic               any_hit,
    output logic               multi_hit,
    output logic [IDX_W-1:0]   sel_idx
);

    always_comb begin
        sel_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) sel_idx = IDX_W'(i);
        end
        any_hit   = |hit_vec;
        multi_hit = (hit_vec & (hit_vec - ENTRIES'(1))) != '0;
    end

    // R7: the chosen slot really matched and no lower slot did
    p_sel_lowest_r7: assert property (@(posedge clk) disable iff (!rst_n)
        any_hit |-> (hit_vec[sel_idx] && ((hit_vec & ((ENTRIES'(1) << sel_idx) - ENTRIES'(1))) == '0)));

    p_multi_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        multi_hit |-> ($countones(hit_vec) > 1));

endmodule

// File: rtl/vtlb_top.sv
module vtlb_top
    import vtlb_pkg::*;
#(
    parameter int ENTRIES = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_req,
    input  logic [EA_W-1:0]   lk_ea,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              sw_idx_we,
    input  logic [IDX_W-1:0]  sw_idx_wdata,
    input  logic              sw_data_we,
    input  logic [DATA_W-1:0] sw_data_wdata,
    input  logic              sw_tag_we,
    input  logic [TAG_W-1:0]  sw_tag_wdata,
    output logic              lk_done,
    output logic              lk_hit,
    output logic              lk_multi,
    output logic [EA_W-1:0]   lk_pa,
    output logic [APG_W-1:0]  lk_prot,
    output logic              lk_guarded,
    output logic              lk_wt,
    output logic              lk_ci,
    output logic [TAG_W-1:0]  rb_tag,
    output logic [DATA_W-1:0] rb_data
);

    typedef struct packed {
        tag_t  [ENTRIES-1:0] tag;
        data_t [ENTRIES-1:0] data;
        logic  [IDX_W-1:0]   idx;
        tag_t                rb_tag;
        data_t               rb_data;
        res_t                res;
    } state_t;

    state_t st_d, st_q;

    logic [ENTRIES-1:0] hit_vec;
    logic               any_hit;
    logic               multi_hit;
    logic [IDX_W-1:0]   sel_idx;

    vtlb_match #(.ENTRIES(ENTRIES)) u_match (
        .tags     (st_q.tag),
        .ea_pn    (lk_ea[EA_W-1:OFS_W]),
        .cur_asid (lk_asid),
        .hit_vec  (hit_vec)
    );

    vtlb_prio #(.ENTRIES(ENTRIES)) u_prio (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit_vec   (hit_vec),
        .any_hit   (any_hit),
        .multi_hit (multi_hit),
        .sel_idx   (sel_idx)
    );

    always_comb begin
        tag_t  win_tag;
        data_t win_data;

        st_d     = st_q;
        win_tag  = st_q.tag[sel_idx];
        win_data = st_q.data[sel_idx];

        if (sw_idx_we) st_d.idx = sw_idx_wdata;

        if (sw_data_we) st_d.data[st_q.idx] = data_t'(sw_data_wdata);

        if (sw_tag_we) begin
            st_d.tag[st_q.idx] = tag_t'(sw_tag_wdata);
            st_d.rb_tag        = tag_t'(sw_tag_wdata);
            st_d.rb_data       = st_d.data[st_q.idx];
        end

        // lookup uses the contents before this edge's writes
        st_d.res      = '0;
        st_d.res.done = lk_req;
        if (lk_req && any_hit) begin
            st_d.res.hit     = 1'b1;
            st_d.res.multi   = multi_hit;
            st_d.res.pa      = make_pa(lk_ea, win_data.rpn, win_tag.ps);
            st_d.res.prot    = ~win_data.apg_inv;
            st_d.res.guarded = win_data.guarded;
            st_d.res.wt      = win_data.wt;
            st_d.res.ci      = win_data.ci;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lk_done    = st_q.res.done;
    assign lk_hit     = st_q.res.hit;
    assign lk_multi   = st_q.res.multi;
    assign lk_pa      = st_q.res.pa;
    assign lk_prot    = st_q.res.prot;
    assign lk_guarded = st_q.res.guarded;
    assign lk_wt      = st_q.res.wt;
    assign lk_ci      = st_q.res.ci;
    assign rb_tag     = st_q.rb_tag;
    assign rb_data    = st_q.rb_data;

    p_done_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> lk_done);

    p_idle_no_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !lk_done && !lk_hit);

    p_multi_needs_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lk_multi |-> lk_hit);

    p_miss_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_pa == '0 && lk_prot == '0 && !lk_guarded && !lk_wt && !lk_ci));

    p_offset_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> (!lk_hit || lk_pa[OFS_W-1:0] == $past(lk_ea[OFS_W-1:0])));

    p_rb_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_tag_we |=> ($stable(rb_tag) && $stable(rb_data)));

    p_rb_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sw_tag_we |=> rb_tag == $past(sw_tag_wdata));

endmodule

// File: tb/vtlb_top_tb.sv
module vtlb_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_req = 1'b0;
    logic [31:0] lk_ea = '0;
    logic [3:0]  lk_asid = '0;
    logic        sw_idx_we = 1'b0;
    logic [4:0]  sw_idx_wdata = '0;
    logic        sw_data_we = 1'b0;
    logic [29:0] sw_data_wdata = '0;
    logic        sw_tag_we = 1'b0;
    logic [28:0] sw_tag_wdata = '0;
    logic        lk_done, lk_hit, lk_multi, lk_guarded, lk_wt, lk_ci;
    logic [31:0] lk_pa;
    logic [3:0]  lk_prot;
    logic [28:0] rb_tag;
    logic [29:0] rb_data;

    int total = 0;
    int bad   = 0;

    logic [28:0] m_tag  [32];
    logic [29:0] m_data [32];

    always #2 clk = ~clk;

    vtlb_top u_dut (
        .clk(clk), .rst_n(rst_n),
        .lk_req(lk_req), .lk_ea(lk_ea), .lk_asid(lk_asid),
        .sw_idx_we(sw_idx_we), .sw_idx_wdata(sw_idx_wdata),
        .sw_data_we(sw_data_we), .sw_data_wdata(sw_data_wdata),
        .sw_tag_we(sw_tag_we), .sw_tag_wdata(sw_tag_wdata),
        .lk_done(lk_done), .lk_hit(lk_hit), .lk_multi(lk_multi), .lk_pa(lk_pa),
        .lk_prot(lk_prot), .lk_guarded(lk_guarded), .lk_wt(lk_wt), .lk_ci(lk_ci),
        .rb_tag(rb_tag), .rb_data(rb_data)
    );

    task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", rq, act, exp);
        end
    endtask

    // page-number bits left out of the compare; -1 for reserved codes
    function automatic int low_bits(input logic [2:0] ps);
        case (ps)
            3'b000: return 0;
            3'b001: return 2;
            3'b011: return 7;
            3'b111: return 11;
            default: return -1;
        endcase
    endfunction

    // {hit, multi, pa[31:0], prot[3:0], g, wt, ci}
    function automatic logic [40:0] model(input logic [31:0] ea, input logic [3:0] asid);
        bit hit = 0;
        bit multi = 0;
        int sel = 0;
        int k;
        logic [31:0] pa;
        logic [31:0] lowm;
        logic [29:0] d;
        for (int i = 0; i < 32; i++) begin
            k = low_bits(m_tag[i][7:5]);
            if (m_tag[i][8] && k >= 0 &&
                ((m_tag[i][28:9] >> k) == (ea[31:12] >> k)) &&
                (m_tag[i][4] || m_tag[i][3:0] == asid)) begin
                if (hit) multi = 1;
                else begin hit = 1; sel = i; end
            end
        end
        if (!hit) return '0;
        k    = low_bits(m_tag[sel][7:5]);
        d    = m_data[sel];
        lowm = (32'd1 << (12 + k)) - 32'd1;
        pa   = ({d[29:10], 12'h000} & ~lowm) | (ea & lowm);
        return {1'b1, multi, pa, ~d[6:3], d[2], d[1], d[0]};
    endfunction

    function automatic logic [40:0] actual();
        return {lk_hit, lk_multi, lk_pa, lk_prot, lk_guarded, lk_wt, lk_ci};
    endfunction

    function automatic logic [28:0] mk_tag(input logic [19:0] epn, input bit v,
                                           input logic [2:0] ps, input bit sh, input logic [3:0] as);
        return {epn, v, ps, sh, as};
    endfunction

    // R11: index first, then data half, then tag half
    task automatic write_entry(input int idx, input logic [28:0] t, input logic [29:0] d);
        logic [28:0] rbt_before;
        logic [29:0] rbd_before;
        @(negedge clk);
        sw_idx_we = 1; sw_idx_wdata = 5'(idx);
        @(negedge clk);
        sw_idx_we = 0; sw_data_we = 1; sw_data_wdata = d;
        rbt_before = rb_tag; rbd_before = rb_data;
        @(negedge clk);
        sw_data_we = 0;
        chk(rb_tag == rbt_before && rb_data == rbd_before, "R10 data write leaves readback",
            {5'b0, rb_tag, rb_data}, {5'b0, rbt_before, rbd_before});
        sw_tag_we = 1; sw_tag_wdata = t;
        @(negedge clk);
        sw_tag_we = 0;
        m_tag[idx] = t; m_data[idx] = d;
        chk(rb_tag == t && rb_data == d, "R10 readback after tag write",
            {5'b0, rb_tag, rb_data}, {5'b0, t, d});
    endtask

    task automatic lookup(input logic [31:0] ea, input logic [3:0] asid, input string rq);
        logic [40:0] e;
        e = model(ea, asid);
        @(negedge clk);
        lk_req = 1; lk_ea = ea; lk_asid = asid;
        @(negedge clk);
        lk_req = 0;
        chk(lk_done == 1'b1, "R2 done after request", 64'(lk_done), 64'(1));
        chk(actual() == e, rq, 64'(actual()), 64'(e));
    endtask

    task automatic clear_all();
        for (int i = 0; i < 32; i++) write_entry(i, '0, '0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [19:0] pool [4];
        void'($urandom(32'h5EED));
        for (int i = 0; i < 32; i++) begin m_tag[i] = '0; m_data[i] = '0; end
        pool[0] = 20'h12340; pool[1] = 20'hABC00; pool[2] = 20'h00000; pool[3] = 20'hFFF80;

        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(!lk_done && !lk_hit && !lk_multi, "R1 reset outputs low",
            64'({lk_done, lk_hit, lk_multi}), 64'(0));
        chk(rb_tag == '0 && rb_data == '0, "R1 readback zero", {5'b0, rb_tag, rb_data}, 64'(0));
        lookup(32'h0000_0000, 4'h0, "R1 empty table misses");
        @(negedge clk);
        chk(!lk_done, "R2 done drops when idle", 64'(lk_done), 64'(0));

        // R3 page size masks, R6 address join, R8 attributes
        write_entry(5, mk_tag(20'h12344, 1, 3'b001, 1, 4'h0), {20'hABCD0, 3'b001, 4'b1010, 3'b101});
        lookup(32'h1234_7ABC, 4'h9, "R3 16K low 2 bits ignored");
        lookup(32'h1234_8ABC, 4'h9, "R3 16K bit 2 compared");
        lookup(32'h1234_4FFF, 4'h3, "R6 R8 16K join and attributes");
        write_entry(6, mk_tag(20'h40000, 1, 3'b011, 1, 4'h0), {20'h5557F, 3'b011, 4'b0001, 3'b010});
        lookup(32'h4007_F123, 4'h1, "R3 512K low 7 bits ignored");
        lookup(32'h4008_0123, 4'h1, "R3 512K bit 7 compared");
        write_entry(7, mk_tag(20'h80000, 1, 3'b111, 1, 4'h0), {20'hFFFFF, 3'b111, 4'b0110, 3'b001});
        lookup(32'h807F_F000, 4'h2, "R3 R6 8M low 11 bits ignored");
        lookup(32'h8080_0000, 4'h2, "R3 8M bit 11 compared");
        write_entry(8, mk_tag(20'h00100, 1, 3'b000, 1, 4'h0), {20'h00200, 3'b000, 4'b1111, 3'b000});
        lookup(32'h0010_0FFF, 4'h0, "R3 4K full compare hit");
        lookup(32'h0010_1000, 4'h0, "R3 4K bit 0 compared");

        // R4 reserved codes and invalid
        write_entry(9, mk_tag(20'h77700, 1, 3'b010, 1, 4'h0), 30'h3FFFFFFF);
        write_entry(10, mk_tag(20'h77700, 1, 3'b110, 1, 4'h0), 30'h3FFFFFFF);
        lookup(32'h7770_0000, 4'h0, "R4 reserved page size never matches");
        write_entry(11, mk_tag(20'h66600, 0, 3'b000, 1, 4'h0), 30'h3FFFFFFF);
        lookup(32'h6660_0000, 4'h0, "R4 invalid never matches");

        // R5 address space identifier
        write_entry(12, mk_tag(20'h33300, 1, 3'b000, 0, 4'h5), {20'h11111, 3'b000, 4'b0011, 3'b100});
        lookup(32'h3330_0010, 4'h5, "R5 private asid equal hits");
        lookup(32'h3330_0010, 4'h6, "R5 private asid differs misses");

        // R7 priority and multi-hit
        write_entry(20, mk_tag(20'h55500, 1, 3'b000, 1, 4'h0), {20'h0AAAA, 3'b000, 4'b0100, 3'b111});
        write_entry(3, mk_tag(20'h55500, 1, 3'b001, 1, 4'h0), {20'h0BBBB, 3'b001, 4'b1000, 3'b011});
        lookup(32'h5550_0020, 4'h0, "R7 lowest index wins with multi");
        lookup(32'h5550_1020, 4'h0, "R7 single match no multi");

        // R9 same-cycle write and lookup
        @(negedge clk);
        sw_idx_we = 1; sw_idx_wdata = 5'd11;
        @(negedge clk);
        sw_idx_we = 0;
        sw_tag_we = 1; sw_tag_wdata = mk_tag(20'h66600, 1, 3'b000, 1, 4'h0);
        lk_req = 1; lk_ea = 32'h6660_0000; lk_asid = 4'h0;
        @(negedge clk);
        sw_tag_we = 0; lk_req = 0;
        chk(lk_done && !lk_hit, "R9 same-cycle lookup sees old slot",
            64'({lk_done, lk_hit}), 64'(2'b10));
        m_tag[11] = mk_tag(20'h66600, 1, 3'b000, 1, 4'h0);
        lookup(32'h6660_0000, 4'h0, "R9 next-cycle lookup sees new slot");

        // random phase
        clear_all();
        for (int n = 0; n < 300; n++) begin
            if ($urandom % 3 == 0) begin
                logic [19:0] ep;
                ep = pool[$urandom % 4] ^ 20'($urandom % 16);
                write_entry(int'($urandom % 32),
                            mk_tag(ep, ($urandom % 8) != 0, 3'($urandom), 1'($urandom), 4'($urandom % 4)),
                            30'($urandom));
            end else begin
                logic [19:0] lp;
                lp = pool[$urandom % 4] ^ 20'($urandom % 32);
                lookup({lp, 12'($urandom)}, 4'($urandom % 4), "R3 R5 R6 R7 R8 random lookup");
            end
        end

        @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule